// File: doc/BRIEF.md
# Dual-Converter Conversion Trigger Sequencer

This block decides when a pair of data converters start a conversion. Converter 0 is the host and converter 1 is its paired client. A start event or a software trigger launches a conversion on one or both converters, depending on the trigger mode and on whether the pair is enabled. Each converter has a cycle-count model of its conversion time. A start pulse begins the count and a busy flag is held for its length. The length grows when gain/offset correction is on or when rail-to-rail sampling is selected.

Configuration reaches the block through a small write port. A written value is applied two clock edges later, and a sync-busy flag is high while the value is pending. In free-running operation each converter starts again as soon as its conversion ends. A trigger aimed at a busy converter is dropped and raises a sticky overrun flag. Rail-to-rail sampling without offset compensation is reported as a configuration error.

Top module: `conv_trig_seq`

## Requirements
- R1: After reset, all outputs are 0, the applied configuration is all zero (single-shot, simultaneous mode, no options) and the alternation pointer selects converter 0.
- R2: A `cfg_wr` pulse captures `cfg_wdata`, with bit 0 as free-run, bit 1 as correction enable, bit 2 as rail-to-rail enable and bits 4:3 as trigger mode. The value is applied at the second rising edge after the edge that samples the write. `sync_busy` is high for exactly the two cycles between these edges. A write that arrives while `sync_busy` is high is dropped.
- R3: `evt_start` and `sw_start` high in the same cycle count as one trigger. With `pair_en` low, a trigger starts converter 0 only, whatever the mode.
- R4: With `pair_en` high and trigger mode 0, a trigger starts both converters in the same cycle. The reserved codes 2 and 3 behave like code 0.
- R5: With `pair_en` high and trigger mode 1, accepted triggers go to converter 0, then 1, then 0, and so on. Every applied configuration write returns the pointer to converter 0.
- R6: The start pulse of a converter (`conv_start[i]`) lasts one cycle and follows the edge that samples the trigger. `conv_busy[i]` rises in that same cycle and stays high for exactly the conversion length.
- R7: The conversion length is the sampling period plus 12 cycles. The sampling period is 2 cycles, or 4 cycles with rail-to-rail enabled. Correction adds another 13 cycles. The defaults therefore give 14, 16, 27 or 29 cycles.
- R8: When a conversion ends with free-run set, the same converter starts again at once: it gives a new start pulse and its busy flag stays high. With free-run clear, busy falls.
- R9: If any converter targeted by a trigger is busy, the whole trigger is ignored: nothing starts and the alternation pointer does not move. `overrun` then goes high and stays high until reset.
- R10: `cfg_err` is high exactly when the applied rail-to-rail bit is 1 and `offcomp_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 5 | Configuration value (fields per R2) |
| pair_en | input | 1 | Host-client pairing enable |
| offcomp_en | input | 1 | Offset compensation enabled |
| evt_start | input | 1 | Start event |
| sw_start | input | 1 | Software trigger |
| conv_start | output | 2 | One-cycle start pulse per converter |
| conv_busy | output | 2 | Conversion in progress per converter |
| sync_busy | output | 1 | Configuration write pending |
| cfg_err | output | 1 | Rail-to-rail selected without offset compensation |
| overrun | output | 1 | Sticky flag for a dropped trigger |

## Verification
Directed phases test each routing pattern on its own:
- A lone trigger with pairing off separates host-only routing from any leak to the client.
- Mode 0 and a reserved code show simultaneous launch.
- Spaced triggers in mode 1 show whether the pointer alternates and whether a rewrite resets it.

Triggers spaced wider and narrower than the conversion length separate acceptance from overrun. Each option combination gives its own busy length, and free-run shows restart without a busy gap. A seeded random run then mixes triggers, writes during sync, pairing changes and option changes, and compares every cycle against a requirement-level model.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;

    typedef struct packed {
        logic [1:0] mode;
        logic       r2r;
        logic       corr;
        logic       frun;
    } seq_cfg_t;

    localparam logic [1:0] MODE_BOTH = 2'd0;
    localparam logic [1:0] MODE_ALT  = 2'd1;

    function automatic seq_cfg_t unpack_cfg(input logic [4:0] w);
        seq_cfg_t c;
        c.frun = w[0];
        c.corr = w[1];
        c.r2r  = w[2];
        c.mode = w[4:3];
        return c;
    endfunction

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync
    import trig_seq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_i,
    input  logic [4:0] wdata_i,
    output seq_cfg_t cfg_o,
    output logic     apply_o,
    output logic     busy_o
);
    localparam int CNTW = $clog2(SYNC_STAGES + 1);

    typedef struct packed {
        seq_cfg_t        pend;
        seq_cfg_t        cfg;
        logic [CNTW-1:0] cnt;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        apply_o = (st_q.cnt == CNTW'(1));
        if (apply_o) begin
            st_d.cfg = st_q.pend;
            st_d.cnt = '0;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - CNTW'(1);
        end else if (wr_i) begin
            st_d.pend = unpack_cfg(wdata_i);
            st_d.cnt  = CNTW'(SYNC_STAGES);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_o  = st_q.cfg;
    assign busy_o = (st_q.cnt != '0);

    // R2: applied configuration only moves after a pending write
    a_r2_cfg_after_sync: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_o) |-> $past(busy_o));
    // R2: an accepted write raises sync busy
    a_r2_write_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !busy_o) |=> busy_o);

endmodule

// File: rtl/conv_timer.sv
module conv_timer #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch_i,
    input  logic [CW-1:0] dur_i,
    input  logic          frun_i,
    output logic          start_o,
    output logic          busy_o
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          st;
    } tmr_st_t;

    tmr_st_t t_d, t_q;
    logic    last;

    always_comb begin
        t_d    = t_q;
        t_d.st = 1'b0;
        last   = (t_q.cnt == CW'(1));
        if (launch_i) begin
            t_d.cnt = dur_i;
            t_d.st  = 1'b1;
        end else if (last) begin
            if (frun_i) begin
                t_d.cnt = dur_i;
                t_d.st  = 1'b1;
            end else begin
                t_d.cnt = '0;
            end
        end else if (t_q.cnt != '0) begin
            t_d.cnt = t_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign start_o = t_q.st;
    assign busy_o  = (t_q.cnt != '0);

    // R6: busy never rises without a start pulse
    a_r6_busy_rise_has_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> start_o);
    // R9: the sequencer never launches a busy converter
    a_r9_no_launch_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        launch_i |-> !busy_o);
    // R8: free-run restarts without a busy gap
    a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (last && frun_i) |=> (start_o && busy_o));

endmodule

// File: rtl/conv_trig_seq.sv
module conv_trig_seq
    import trig_seq_pkg::*;
#(
    parameter int SYNC_CYC = 2,
    parameter int SAMP_CYC = 2,
    parameter int R2R_SAMP = 4,
    parameter int BASE_CYC = 12,
    parameter int CORR_CYC = 13
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic [4:0] cfg_wdata,
    input  logic       pair_en,
    input  logic       offcomp_en,
    input  logic       evt_start,
    input  logic       sw_start,
    output logic [1:0] conv_start,
    output logic [1:0] conv_busy,
    output logic       sync_busy,
    output logic       cfg_err,
    output logic       overrun
);
    localparam int NCONV  = 2;
    localparam int SAMPMX = (R2R_SAMP > SAMP_CYC) ? R2R_SAMP : SAMP_CYC;
    localparam int MAXDUR = BASE_CYC + CORR_CYC + SAMPMX;
    localparam int CW     = $clog2(MAXDUR + 1);

    typedef struct packed {
        logic tog;
        logic ovr;
    } seq_st_t;

    seq_cfg_t         cfg;
    logic             apply;
    logic             trig;
    logic             blocked;
    logic [NCONV-1:0] tgt;
    logic [NCONV-1:0] launch;
    logic [CW-1:0]    dur;
    seq_st_t          s_d, s_q;

    cfg_sync #(.SYNC_STAGES(SYNC_CYC)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (cfg_wr),
        .wdata_i (cfg_wdata),
        .cfg_o   (cfg),
        .apply_o (apply),
        .busy_o  (sync_busy)
    );

    always_comb begin
        dur = CW'(BASE_CYC)
            + (cfg.r2r  ? CW'(R2R_SAMP) : CW'(SAMP_CYC))
            + (cfg.corr ? CW'(CORR_CYC) : CW'(0));
    end

    always_comb begin
        s_d  = s_q;
        trig = evt_start | sw_start;
        if (!pair_en)                tgt = 2'b01;
        else if (cfg.mode == MODE_ALT) tgt = s_q.tog ? 2'b10 : 2'b01;
        else                         tgt = 2'b11;
        blocked = |(tgt & conv_busy);
        launch  = (trig && !blocked) ? tgt : '0;
        if (trig && blocked) s_d.ovr = 1'b1;
        if (apply)
            s_d.tog = 1'b0;
        else if (trig && !blocked && pair_en && cfg.mode == MODE_ALT)
            s_d.tog = !s_q.tog;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    for (genvar g = 0; g < NCONV; g++) begin : g_conv
        conv_timer #(.CW(CW)) tmr_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .launch_i (launch[g]),
            .dur_i    (dur),
            .frun_i   (cfg.frun),
            .start_o  (conv_start[g]),
            .busy_o   (conv_busy[g])
        );
    end

    assign overrun = s_q.ovr;
    assign cfg_err = cfg.r2r & ~offcomp_en;

    // R9: overrun is sticky
    a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);
    // R3: with pairing off an idle host is started by a trigger
    a_r3_host_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!pair_en && (evt_start || sw_start) && !conv_busy[0]) |=> conv_start[0]);
    // R4: simultaneous mode launches both idle converters together
    a_r4_both: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_en && cfg.mode == MODE_BOTH && (evt_start || sw_start) && conv_busy == 2'b00)
        |=> conv_start == 2'b11);

endmodule

// File: tb/conv_trig_seq_tb.sv
module conv_trig_seq_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [4:0] cfg_wdata = '0;
    logic       pair_en = 1'b0;
    logic       offcomp_en = 1'b0;
    logic       evt_start = 1'b0;
    logic       sw_start = 1'b0;
    logic [1:0] conv_start;
    logic [1:0] conv_busy;
    logic       sync_busy;
    logic       cfg_err;
    logic       overrun;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    conv_trig_seq dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .pair_en(pair_en), .offcomp_en(offcomp_en), .evt_start(evt_start),
        .sw_start(sw_start), .conv_start(conv_start), .conv_busy(conv_busy),
        .sync_busy(sync_busy), .cfg_err(cfg_err), .overrun(overrun)
    );

    // reference model, written from the requirements
    int         m_scnt;
    logic [4:0] m_pend, m_cfg;
    logic       m_tog, m_ov, m_trig, m_blk, m_ntog;
    logic [1:0] m_tgt, m_st;
    int         m_cnt [2];
    int         m_dur;

    function automatic int dur_of(logic [4:0] c);
        return 12 + (c[2] ? 4 : 2) + (c[1] ? 13 : 0); // R7
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_scnt = 0; m_pend = '0; m_cfg = '0; m_tog = 0; m_ov = 0;
            m_st = '0; m_cnt[0] = 0; m_cnt[1] = 0;
        end else begin
            m_trig = evt_start | sw_start;
            if (!pair_en)               m_tgt = 2'b01;
            else if (m_cfg[4:3] == 2'd1) m_tgt = m_tog ? 2'b10 : 2'b01;
            else                        m_tgt = 2'b11;
            m_blk = (m_tgt[0] && m_cnt[0] != 0) || (m_tgt[1] && m_cnt[1] != 0);
            m_dur = dur_of(m_cfg);
            for (int i = 0; i < 2; i++) begin
                if (m_trig && !m_blk && m_tgt[i]) begin
                    m_cnt[i] = m_dur; m_st[i] = 1'b1;
                end else if (m_cnt[i] == 1) begin
                    if (m_cfg[0]) begin m_cnt[i] = m_dur; m_st[i] = 1'b1; end
                    else begin m_cnt[i] = 0; m_st[i] = 1'b0; end
                end else begin
                    if (m_cnt[i] != 0) m_cnt[i] = m_cnt[i] - 1;
                    m_st[i] = 1'b0;
                end
            end
            if (m_trig && m_blk) m_ov = 1'b1;
            m_ntog = m_tog;
            if (m_trig && !m_blk && pair_en && m_cfg[4:3] == 2'd1) m_ntog = !m_tog;
            if (m_scnt == 1) begin
                m_cfg = m_pend; m_scnt = 0; m_ntog = 1'b0;
            end else if (m_scnt != 0) begin
                m_scnt = m_scnt - 1;
            end else if (cfg_wr) begin
                m_pend = cfg_wdata; m_scnt = 2;
            end
            m_tog = m_ntog;
        end
    end

    task automatic chk(string rq, string what, string ph, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s (phase %s) actual %0d expected %0d", rq, what, ph, act, exp);
        end
    endtask

    task automatic compare(string ph);
        chk("R5",  "conv_start", ph, int'(conv_start), int'(m_st));
        chk("R6",  "conv_busy",  ph, int'(conv_busy),
            int'({m_cnt[1] != 0, m_cnt[0] != 0}));
        chk("R2",  "sync_busy",  ph, int'(sync_busy), int'(m_scnt != 0));
        chk("R10", "cfg_err",    ph, int'(cfg_err), int'(m_cfg[2] && !offcomp_en));
        chk("R9",  "overrun",    ph, int'(overrun), int'(m_ov));
    endtask

    task automatic step(bit e, bit s, bit w, logic [4:0] wd, string ph);
        @(negedge clk);
        compare(ph);
        evt_start = e; sw_start = s; cfg_wr = w; cfg_wdata = wd;
    endtask

    task automatic idle(int n, string ph);
        repeat (n) step(0, 0, 0, 5'd0, ph);
    endtask

    // writes a value and waits until it is applied
    task automatic wcfg(logic [4:0] v, string ph);
        step(0, 0, 1, v, ph);
        idle(3, ph);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4127));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        @(negedge clk);
        chk("R1", "outputs", "R1",
            int'({conv_start, conv_busy, sync_busy, cfg_err, overrun}), 0);
        idle(2, "R1");

        // R3: pairing off, single event then both trigger sources together
        pair_en = 0;
        step(1, 0, 0, 5'd0, "R3"); idle(18, "R3");
        step(1, 1, 0, 5'd0, "R3"); idle(18, "R3");

        // R2: write, then a second write during sync is dropped
        pair_en = 1;
        step(0, 0, 1, 5'b00_000, "R2");
        step(0, 0, 1, 5'b01_011, "R2");
        idle(4, "R2");

        // R4: simultaneous mode, then reserved code 2
        step(0, 1, 0, 5'd0, "R4"); idle(18, "R4");
        wcfg(5'b10_000, "R4");
        step(1, 0, 0, 5'd0, "R4"); idle(18, "R4");

        // R5: alternation and reset of the pointer on rewrite
        wcfg(5'b01_000, "R5");
        for (int k = 0; k < 3; k++) begin step(1, 0, 0, 5'd0, "R5"); idle(16, "R5"); end
        wcfg(5'b01_000, "R5");
        step(0, 1, 0, 5'd0, "R5"); idle(16, "R5");

        // R7: each option combination gives its own length
        for (int c = 0; c < 4; c++) begin
            wcfg({2'b00, c[1:0], 1'b0}, "R7");
            step(1, 0, 0, 5'd0, "R7"); idle(31, "R7");
        end
        offcomp_en = 1; idle(2, "R10");
        offcomp_en = 0; wcfg(5'd0, "R10");

        // R9: trigger inside a running conversion
        step(1, 0, 0, 5'd0, "R9"); idle(3, "R9");
        step(0, 1, 0, 5'd0, "R9"); idle(16, "R9");

        // R8: free-run restarts, then back to single-shot
        wcfg(5'b00_001, "R8");
        step(1, 0, 0, 5'd0, "R8"); idle(50, "R8");
        wcfg(5'b00_000, "R8"); idle(20, "R8");

        // constrained random mix
        for (int n = 0; n < 6000; n++) begin
            if ($urandom_range(0, 199) == 0) pair_en = ~pair_en;
            if ($urandom_range(0, 99) == 0) offcomp_en = ~offcomp_en;
            step($urandom_range(0, 9) == 0, $urandom_range(0, 11) == 0,
                 $urandom_range(0, 39) == 0, 5'($urandom_range(0, 31)), "RND");
        end
        idle(2, "RND");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule